// File: doc/BRIEF.md
# Conflict-Miss Victim Buffer

This block is a small, fully associative store that sits beside a direct-mapped cache. It catches the lines that the cache throws out. Each slot holds one whole line, the complete block address of that line, and a comparator of its own, so every slot is checked in the same cycle. The buffer is never filled by demand fetches. Its only sources are evictions from the main cache and the lines that come back to it during a swap.

The surrounding controller queries the buffer only after the main cache reports a miss. A lookup returns its hit flag and line one cycle after the request, which is the one extra cycle that a buffer hit costs. On a hit, the controller moves the returned line into the main cache and issues a swap. The swap names the address that hit and carries the line being pushed out of the main cache. That displaced line takes over the same slot in one clock edge. If the lookup misses, the request goes on to the next level of memory. When that fill later evicts a line from the main cache, the evicted line is offered to the buffer through the insert port.

Slot choice on insert works in two steps. The lowest-numbered empty slot is taken first. If no slot is empty, the least recently used slot is replaced. The age order starts with slot 0 as the youngest and the highest slot as the oldest.

Top module: `victim_buffer`

## Requirements
- R1: After reset every slot is empty, and a lookup of any address returns hit 0 with line data 0.
- R2: A lookup request (`lk_valid` high with `lk_addr`) is answered on the clock edge that follows it. `lk_hit` goes to 1 with the stored line on `lk_data` when a valid slot holds exactly that block address. Otherwise `lk_hit` is 0 and `lk_data` is 0.
- R3: An insert of an address not already held goes to the lowest-indexed empty slot, and no held line is lost while any slot is empty.
- R4: When all slots are valid, an insert of a new address replaces the least recently used line. An insert or a swap that keeps the slot valid makes that slot the most recently used. Lookups do not change the order.
- R5: An insert whose address is already held overwrites that slot's line in place and makes it most recently used. No second copy is created.
- R6: A swap (`sw_en`) whose `sw_addr` matches a valid slot replaces that slot's address and line with `sw_line_addr` and `sw_line_data` when `sw_line_vld` is 1. After the swap, the old address misses and the new one hits.
- R7: A matching swap with `sw_line_vld` 0 empties the slot, and the next insert of a new address reuses it.
- R8: A swap whose `sw_addr` matches no valid slot changes nothing.
- R9: An insert presented in the same cycle as a swap is dropped. Only the swap takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Block address to search |
| lk_hit | output | 1 | Lookup hit, one cycle after the request |
| lk_data | output | LINE_W | Line of the hitting slot, zero on a miss |
| ins_en | input | 1 | Insert an evicted line |
| ins_addr | input | ADDR_W | Full block address of the evicted line |
| ins_data | input | LINE_W | Evicted line |
| sw_en | input | 1 | Swap request |
| sw_addr | input | ADDR_W | Block address that hit and leaves the buffer |
| sw_line_vld | input | 1 | The displaced main-cache line is valid |
| sw_line_addr | input | ADDR_W | Block address of the displaced line |
| sw_line_data | input | LINE_W | Displaced line |

## Verification
Any error in slot state shows at the ports as a wrong hit flag or a wrong line on the lookup that follows. Every slot is visible through a sweep of the whole address space, so a bad tag, line or valid bit appears within one sweep of the operation that caused it. A corrupted age order stays hidden until the buffer is full and a new line is inserted. It then shows as the wrong line vanishing, which the next sweep finds both as an unexpected miss and as an unexpected surviving hit.

// File: rtl/vbuf_pkg.sv
package vbuf_pkg;
   // index width that stays legal for a single-slot corner
   function automatic int slot_bits(input int n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/vbuf_match.sv
module vbuf_match
   import vbuf_pkg::*;
#(
   parameter int ENTRIES = 4,
   parameter int KEY_W   = 8,
   localparam int IDX_W  = slot_bits(ENTRIES)
) (
   input  logic [ENTRIES-1:0][KEY_W-1:0] tags,
   input  logic [ENTRIES-1:0]            valid,
   input  logic [KEY_W-1:0]              key,
   output logic [ENTRIES-1:0]            hit_vec,
   output logic                          hit,
   output logic [IDX_W-1:0]              idx
);
   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hit_vec[g] = valid[g] && (tags[g] == key);
   end

   assign hit = |hit_vec;

   // tags are unique, so the vector is at most one-hot: OR the indices
   always_comb begin
      idx = '0;
      for (int i = 0; i < ENTRIES; i++)
         if (hit_vec[i]) idx = idx | IDX_W'(i);
   end
endmodule

// File: rtl/vbuf_lru.sv
module vbuf_lru
   import vbuf_pkg::*;
#(
   parameter int ENTRIES = 4,
   localparam int IDX_W  = slot_bits(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRIES-1:0] valid,
   input  logic               touch_en,
   input  logic [IDX_W-1:0]   touch_idx,
   output logic [IDX_W-1:0]   victim_idx
);
   localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

   // ages form a permutation of 0..ENTRIES-1; 0 is most recent
   logic [ENTRIES-1:0][IDX_W-1:0] age_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) age_q[i] <= IDX_W'(i);
      end else if (touch_en) begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (IDX_W'(i) == touch_idx)
               age_q[i] <= '0;
            else if (age_q[i] < age_q[touch_idx])
               age_q[i] <= age_q[i] + 1'b1;
         end
      end
   end

   // empty slots first (lowest index), else the oldest slot
   always_comb begin
      logic found;
      found      = 1'b0;
      victim_idx = '0;
      for (int i = 0; i < ENTRIES; i++)
         if (!found && !valid[i]) begin
            found      = 1'b1;
            victim_idx = IDX_W'(i);
         end
      if (!found)
         for (int i = 0; i < ENTRIES; i++)
            if (age_q[i] == OLDEST) victim_idx = IDX_W'(i);
   end
endmodule

// File: rtl/victim_buffer.sv
module victim_buffer
   import vbuf_pkg::*;
#(
   parameter int ENTRIES = 4,
   parameter int ADDR_W  = 26,
   parameter int LINE_W  = 256
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [ADDR_W-1:0] lk_addr,
   output logic              lk_hit,
   output logic [LINE_W-1:0] lk_data,
   input  logic              ins_en,
   input  logic [ADDR_W-1:0] ins_addr,
   input  logic [LINE_W-1:0] ins_data,
   input  logic              sw_en,
   input  logic [ADDR_W-1:0] sw_addr,
   input  logic              sw_line_vld,
   input  logic [ADDR_W-1:0] sw_line_addr,
   input  logic [LINE_W-1:0] sw_line_data
);
   localparam int IDX_W = slot_bits(ENTRIES);

   if (ENTRIES < 2)  begin : g_bad_entries  $error("ENTRIES must be at least 2");  end
   if (ADDR_W < 1)   begin : g_bad_addr     $error("ADDR_W must be positive");     end
   if (LINE_W < 1)   begin : g_bad_line     $error("LINE_W must be positive");     end

   logic [ENTRIES-1:0][ADDR_W-1:0] tag_q;
   logic [ENTRIES-1:0][LINE_W-1:0] data_q;
   logic [ENTRIES-1:0]             valid_q;

   logic [ENTRIES-1:0] lk_vec, sw_vec, ins_vec;
   logic               lk_match, sw_hit, ins_dup;
   logic [IDX_W-1:0]   lk_idx, sw_idx, ins_idx, victim_idx;

   vbuf_match #(.ENTRIES(ENTRIES), .KEY_W(ADDR_W)) u_lk_cmp (
      .tags(tag_q), .valid(valid_q), .key(lk_addr),
      .hit_vec(lk_vec), .hit(lk_match), .idx(lk_idx));

   vbuf_match #(.ENTRIES(ENTRIES), .KEY_W(ADDR_W)) u_sw_cmp (
      .tags(tag_q), .valid(valid_q), .key(sw_addr),
      .hit_vec(sw_vec), .hit(sw_hit), .idx(sw_idx));

   vbuf_match #(.ENTRIES(ENTRIES), .KEY_W(ADDR_W)) u_ins_cmp (
      .tags(tag_q), .valid(valid_q), .key(ins_addr),
      .hit_vec(ins_vec), .hit(ins_dup), .idx(ins_idx));

   logic             sw_act, ins_act, touch_en;
   logic [IDX_W-1:0] ins_slot, touch_idx;

   assign sw_act    = sw_en && sw_hit;
   assign ins_act   = ins_en && !sw_en;
   assign ins_slot  = ins_dup ? ins_idx : victim_idx;
   assign touch_en  = (sw_act && sw_line_vld) || ins_act;
   assign touch_idx = sw_act ? sw_idx : ins_slot;

   vbuf_lru #(.ENTRIES(ENTRIES)) u_lru (
      .clk(clk), .rst_n(rst_n), .valid(valid_q),
      .touch_en(touch_en), .touch_idx(touch_idx), .victim_idx(victim_idx));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tag_q   <= '0;
         data_q  <= '0;
         valid_q <= '0;
      end else if (sw_act) begin
         tag_q[sw_idx]   <= sw_line_addr;
         data_q[sw_idx]  <= sw_line_data;
         valid_q[sw_idx] <= sw_line_vld;
      end else if (ins_act) begin
         tag_q[ins_slot]   <= ins_addr;
         data_q[ins_slot]  <= ins_data;
         valid_q[ins_slot] <= 1'b1;
      end
   end

   // lookup sees the contents before this edge's update
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lk_hit  <= 1'b0;
         lk_data <= '0;
      end else begin
         lk_hit  <= lk_valid && lk_match;
         lk_data <= (lk_valid && lk_match) ? data_q[lk_idx] : '0;
      end
   end
endmodule

// File: rtl/victim_buffer_chk.sv
module victim_buffer_chk #(
   parameter int ENTRIES = 4,
   parameter int LINE_W  = 256
) (
   input logic               clk,
   input logic               rst_n,
   input logic               lk_valid,
   input logic               lk_hit,
   input logic [LINE_W-1:0]  lk_data,
   input logic               ins_en,
   input logic               sw_en,
   input logic               sw_line_vld,
   input logic               sw_hit,
   input logic               ins_dup,
   input logic [ENTRIES-1:0] valid_q,
   input logic [ENTRIES-1:0] lk_vec
);
   p_empty_misses_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q == '0) |=> !lk_hit);

   p_hit_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> $past(lk_valid));

   p_miss_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (lk_data == '0));

   p_fill_grows_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_en && !sw_en && !ins_dup && (valid_q != '1)) |=>
         ($countones(valid_q) == $past($countones(valid_q)) + 1));

   p_full_stays_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_en && !sw_en && (valid_q == '1)) |=> (valid_q == '1));

   p_unique_tags_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lk_vec));

   p_swap_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_en && sw_hit && sw_line_vld) |=> $stable(valid_q));

   p_swap_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_en && sw_hit && !sw_line_vld) |=>
         ($countones(valid_q) + 1 == $past($countones(valid_q))));

   p_swap_miss_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_en && !sw_hit) |=> $stable(valid_q));

   p_insert_dropped_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_en && sw_en && !sw_hit) |=> $stable(valid_q));
endmodule

bind victim_buffer victim_buffer_chk #(.ENTRIES(ENTRIES), .LINE_W(LINE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_hit(lk_hit),
   .lk_data(lk_data), .ins_en(ins_en), .sw_en(sw_en),
   .sw_line_vld(sw_line_vld), .sw_hit(sw_hit), .ins_dup(ins_dup),
   .valid_q(valid_q), .lk_vec(lk_vec));

// File: tb/victim_buffer_test.sv
module victim_buffer_test;
   localparam int N  = 4;
   localparam int AW = 6;
   localparam int LW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          lk_valid = 1'b0;
   logic [AW-1:0] lk_addr = '0;
   logic          lk_hit;
   logic [LW-1:0] lk_data;
   logic          ins_en = 1'b0;
   logic [AW-1:0] ins_addr = '0;
   logic [LW-1:0] ins_data = '0;
   logic          sw_en = 1'b0;
   logic [AW-1:0] sw_addr = '0;
   logic          sw_line_vld = 1'b0;
   logic [AW-1:0] sw_line_addr = '0;
   logic [LW-1:0] sw_line_data = '0;

   always #5 clk = ~clk;

   victim_buffer #(.ENTRIES(N), .ADDR_W(AW), .LINE_W(LW)) uut (
      .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_addr(lk_addr),
      .lk_hit(lk_hit), .lk_data(lk_data), .ins_en(ins_en),
      .ins_addr(ins_addr), .ins_data(ins_data), .sw_en(sw_en),
      .sw_addr(sw_addr), .sw_line_vld(sw_line_vld),
      .sw_line_addr(sw_line_addr), .sw_line_data(sw_line_data));

   int vectors = 0;
   int miscompares = 0;
   bit finished = 1'b0;
   int tick = 0;

   // reference: slot contents plus last-use stamps (lowest stamp is oldest)
   bit          m_valid [N];
   int          m_tag   [N];
   logic [LW-1:0] m_data [N];
   int          m_stamp [N];

   function automatic logic [LW-1:0] line_of(input int a, input int k);
      return LW'(a * 37 + k * 1009 + 1);
   endfunction

   function automatic int find(input int a);
      for (int i = 0; i < N; i++) if (m_valid[i] && m_tag[i] == a) return i;
      return -1;
   endfunction

   function automatic void model_insert(input int a, input logic [LW-1:0] d);
      int s;
      s = find(a);
      if (s < 0)
         for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) s = i;
      if (s < 0) begin
         s = 0;
         for (int i = 1; i < N; i++) if (m_stamp[i] < m_stamp[s]) s = i;
      end
      m_valid[s] = 1'b1; m_tag[s] = a; m_data[s] = d;
      tick++; m_stamp[s] = tick;
   endfunction

   function automatic void model_swap(input int a, input int na,
                                      input logic [LW-1:0] nd, input bit nv);
      int s;
      s = find(a);
      if (s >= 0) begin
         m_valid[s] = nv; m_tag[s] = na; m_data[s] = nd;
         if (nv) begin tick++; m_stamp[s] = tick; end
      end
   endfunction

   task automatic do_insert(input int a, input logic [LW-1:0] d);
      @(negedge clk);
      ins_en = 1'b1; ins_addr = AW'(a); ins_data = d;
      @(negedge clk);
      ins_en = 1'b0;
      model_insert(a, d);
   endtask

   task automatic do_swap(input int a, input int na, input logic [LW-1:0] nd,
                          input bit nv, input bit with_ins, input int ia);
      @(negedge clk);
      sw_en = 1'b1; sw_addr = AW'(a); sw_line_vld = nv;
      sw_line_addr = AW'(na); sw_line_data = nd;
      ins_en = with_ins; ins_addr = AW'(ia); ins_data = line_of(ia, 7);
      @(negedge clk);
      sw_en = 1'b0; ins_en = 1'b0;
      model_swap(a, na, nd, nv);
   endtask

   // every block address, one lookup each, checked the cycle after
   task automatic sweep(input string req);
      for (int a = 0; a < (1 << AW); a++) begin
         bit            eh;
         logic [LW-1:0] ed;
         int            s;
         @(negedge clk);
         lk_valid = 1'b1; lk_addr = AW'(a);
         @(negedge clk);
         lk_valid = 1'b0;
         s  = find(a);
         eh = (s >= 0);
         ed = eh ? m_data[s] : '0;
         vectors++;
         if (lk_hit !== eh || lk_data !== ed) begin
            miscompares++;
            $display("FAIL %s addr %0d: hit=%0b data=%h expected hit=%0b data=%h",
                     req, a, lk_hit, lk_data, eh, ed);
         end
      end
   endtask

   initial begin
      for (int i = 0; i < N; i++) begin
         m_valid[i] = 1'b0; m_tag[i] = 0; m_data[i] = '0; m_stamp[i] = -i;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      sweep("R1 empty after reset");

      do_insert(5,  line_of(5, 0));
      do_insert(9,  line_of(9, 0));
      do_insert(17, line_of(17, 0));
      do_insert(33, line_of(33, 0));
      sweep("R3/R2 fill empty slots");

      do_insert(40, line_of(40, 0));          // 5 is oldest
      sweep("R4 LRU eviction");

      do_swap(9, 50, line_of(50, 1), 1'b1, 1'b0, 0);
      sweep("R6 swap in place");

      do_insert(41, line_of(41, 0));          // 17 is oldest now
      sweep("R4 swap refreshes age");

      do_insert(33, line_of(33, 2));
      sweep("R5 duplicate overwrite");

      do_insert(42, line_of(42, 0));          // 40 oldest after 33 refresh
      sweep("R5/R4 order after overwrite");

      do_swap(50, 51, line_of(51, 0), 1'b0, 1'b0, 0);
      sweep("R7 swap frees slot");

      do_insert(60, line_of(60, 0));          // fills the freed slot only
      sweep("R7/R3 freed slot reused");

      do_swap(2, 3, line_of(3, 0), 1'b1, 1'b0, 0);
      sweep("R8 swap miss ignored");

      do_swap(60, 62, line_of(62, 0), 1'b1, 1'b1, 61);
      sweep("R9 insert dropped under swap");

      do_insert(63, line_of(63, 0));
      sweep("R4 eviction after swap");

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      #1_000_000;
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end
endmodule